// File: doc/BRIEF.md
# Static Memory Burst Read Timer

This block sequences the chip-select, output-enable and write-enable strobes for a single static memory bank on a 32-bit data bus. A requester presents an address, a write flag and write data with `req_valid` and holds them until `req_ready` pulses. The bank is configured by a 3-bit device-type code and two 4-bit wait counts. The first-access count applies to any access that starts a new transfer. The next-access count applies to reads that continue a burst.

Burst-capable devices return later reads faster than the first one, but only while the address moves inside an aligned window. The window is 4 words (address bits 3:2) or 8 words (address bits 4:2). The block remembers the last read. It grants the short timing only to a read that stays in the same window and steps to the next word in ascending order. Writes, and every non-burst device code, always take the full first-access time.

Top module: `smbt_burst_timer`

## Requirements
- R1: While reset is asserted and whenever no access is in progress, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high and `req_ready` is low.
- R2: An access lasts wait+1 cycles with `mem_cs_n` low. The wait count is the first-access or next-access count, and values 0 and 15 are both valid. `req_ready` is high for exactly one cycle, in the last of those cycles.
- R3: A write drives `mem_we_n` low and keeps `mem_oe_n` high for the whole access. It always uses first-access timing, even at the next sequential address, and `rsp_burst` stays low.
- R4: With device type 3'b010, a read uses next-access timing and shows `rsp_burst` high when three conditions hold. The previous access was a read. Byte-address bits above bit 3 are unchanged. Bits 3:2 equal the previous value plus one (order 00, 01, 10, 11).
- R5: With device type 3'b011, the same rule applies on bits 4:2, so a run of 8 ascending words at an 8-word-aligned base is one burst.
- R6: A read whose word offset is not the previous offset plus one uses first-access timing and starts a new burst. This covers a backward step, a skipped word, and a step past the top of the window.
- R7: A read whose address bits above the window differ from the previous read uses first-access timing.
- R8: A write between two reads ends the burst, so the read after it uses first-access timing.
- R9: Device types 3'b000, 3'b001, 3'b100 and the unused codes 3'b101, 3'b110 and 3'b111 never use next-access timing.
- R10: The first read after reset uses first-access timing, even when its address would follow the last read before reset.
- R11: `mem_addr` holds the request address for the whole access, and `mem_wdata` holds the write data for the whole access. For a read, `rsp_rdata` holds the value on `mem_rdata` in the last access cycle, from the cycle after `req_ready` onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_type | input | 3 | Device-type code |
| cfg_first_wait | input | 4 | Wait count for a first access |
| cfg_next_wait | input | 4 | Wait count for a continued burst read |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle pulse in the last access cycle |
| rsp_burst | output | 1 | Current access uses next-access timing |
| rsp_rdata | output | 32 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 26 | Address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory |

## Verification
A request is accepted on the first rising edge in which the block is idle. The strobes fall right after that edge, and `req_ready` rises wait cycles later. The bench drives inputs on falling edges and samples on falling edges. It counts the falling edges with `mem_cs_n` low up to and including the one that shows `req_ready`, and compares that count with wait+1. `rsp_burst`, the address, the data and the strobe levels are checked on those same falling edges. `rsp_rdata` and the end of the ready pulse are checked one falling edge later, because read data is registered on the edge that ends the access.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int WIN_W   = 2;
    localparam int MAX_WIN = 3;

    localparam logic [2:0] DT_PLAIN  = 3'b000;
    localparam logic [2:0] DT_SRAM   = 3'b001;
    localparam logic [2:0] DT_BURST4 = 3'b010;
    localparam logic [2:0] DT_BURST8 = 3'b011;
    localparam logic [2:0] DT_VARLAT = 3'b100;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACCESS = 1'b1
    } phase_e;

endpackage

// File: rtl/smbt_type_decode.sv
module smbt_type_decode
    import smbt_pkg::*;
(
    input  logic [2:0]       dev_type,
    output logic [WIN_W-1:0] win_bits
);

    // number of word-address bits that may advance inside a fast burst
    always_comb begin
        case (dev_type)
            DT_BURST4: win_bits = WIN_W'(2);
            DT_BURST8: win_bits = WIN_W'(3);
            default:   win_bits = '0;   // plain, SRAM, variable latency, unused codes
        endcase
    end

endmodule

// File: rtl/smbt_wait_counter.sv
module smbt_wait_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/smbt_burst_tracker.sv
module smbt_burst_tracker
    import smbt_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_W-1:0]  win_bits,
    input  logic              acc_take,
    input  logic              acc_write,
    input  logic [WORD_W-1:0] acc_word,
    output logic              seq_hit
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] last;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [WORD_W-1:0] win_mask;
    logic [WORD_W-1:0] off_cur;
    logic [WORD_W-1:0] off_prev;
    logic              upper_same;
    logic              step_one;

    // window mask: the lowest win_bits word-address bits
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        if (i < MAX_WIN) begin : g_live
            assign win_mask[i] = (win_bits > WIN_W'(i));
        end else begin : g_dead
            assign win_mask[i] = 1'b0;
        end
    end

    always_comb begin
        off_cur    = acc_word   & win_mask;
        off_prev   = trk_q.last & win_mask;
        upper_same = ((acc_word & ~win_mask) == (trk_q.last & ~win_mask));
        step_one   = (off_prev != win_mask) && (off_cur == off_prev + WORD_W'(1));
        seq_hit    = trk_q.valid && !acc_write && (win_bits != '0) && upper_same && step_one;
    end

    always_comb begin
        trk_d = trk_q;
        if (acc_take) begin
            trk_d.valid = !acc_write;   // a write ends any burst
            trk_d.last  = acc_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/smbt_burst_timer.sv
module smbt_burst_timer
    import smbt_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_type,
    input  logic [WAIT_W-1:0] cfg_first_wait,
    input  logic [WAIT_W-1:0] cfg_next_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_burst,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        phase_e            ph;
        logic              wr;
        logic              fast;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WIN_W-1:0]  win_bits;
    logic              seq_hit;
    logic              take;
    logic              cnt_zero;
    logic [WAIT_W-1:0] wait_sel;

    smbt_type_decode u_decode (
        .dev_type (cfg_type),
        .win_bits (win_bits)
    );

    smbt_burst_tracker #(
        .WORD_W (WORD_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_bits  (win_bits),
        .acc_take  (take),
        .acc_write (req_write),
        .acc_word  (req_addr[ADDR_W-1:2]),
        .seq_hit   (seq_hit)
    );

    smbt_wait_counter #(
        .CNT_W (WAIT_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_val (wait_sel),
        .at_zero  (cnt_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        take     = 1'b0;
        wait_sel = cfg_first_wait;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    take        = 1'b1;
                    wait_sel    = seq_hit ? cfg_next_wait : cfg_first_wait;
                    ctl_d.ph    = PH_ACCESS;
                    ctl_d.wr    = req_write;
                    ctl_d.fast  = seq_hit;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                end
            end
            PH_ACCESS: begin
                if (cnt_zero) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.fast = 1'b0;
                    if (!ctl_q.wr) begin
                        ctl_d.rdata = mem_rdata;
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.ph == PH_ACCESS) && cnt_zero;
    assign rsp_burst = ctl_q.fast;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_cs_n  = (ctl_q.ph != PH_ACCESS);
    assign mem_oe_n  = !((ctl_q.ph == PH_ACCESS) && !ctl_q.wr);
    assign mem_we_n  = !((ctl_q.ph == PH_ACCESS) && ctl_q.wr);
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = ctl_q.wdata;

endmodule

// File: rtl/smbt_burst_timer_chk.sv
module smbt_burst_timer_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_type,
    input logic              req_ready,
    input logic              rsp_burst,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: no strobe and no ready outside an access
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n && !req_ready));

    // R2: ready is a single-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R3: read and write strobes never overlap
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R3: writes never take the short timing
    p_write_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |-> !rsp_burst);

    // R9: short timing only for the two burst device codes
    p_burst_type_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && rsp_burst) |-> (cfg_type == 3'b010 || cfg_type == 3'b011));

    // R11: address held for the whole access
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind smbt_burst_timer smbt_burst_timer_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_type  (cfg_type),
    .req_ready (req_ready),
    .rsp_burst (rsp_burst),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr)
);

// File: tb/smbt_burst_timer_tb.sv
`timescale 1ns/1ps
module smbt_burst_timer_tb;

    localparam int ADDR_W = 26;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_type = 3'b010;
    logic [3:0]        cfg_first_wait = 4'd6;
    logic [3:0]        cfg_next_wait = 4'd2;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rsp_burst;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_cs_n, mem_oe_n, mem_we_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    // memory model: data is a fixed function of the address
    function automatic logic [DATA_W-1:0] model_rd(input logic [ADDR_W-1:0] a);
        return {{(DATA_W-ADDR_W){1'b0}}, a} ^ 32'hC3C3_3C3C;
    endfunction
    assign mem_rdata = model_rd(mem_addr);

    smbt_burst_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type),
        .cfg_first_wait(cfg_first_wait), .cfg_next_wait(cfg_next_wait),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_burst(rsp_burst),
        .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_access(input logic [2:0] typ, input logic wr,
                              input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                              output int cyc, output logic fast,
                              output logic [DATA_W-1:0] rd, output logic side_ok,
                              output logic one_pulse);
        @(negedge clk);
        cfg_type  = typ;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        cyc = 0; fast = 1'b0; side_ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!mem_cs_n) begin
                cyc++;
                if (mem_addr !== a) side_ok = 1'b0;
                if (wr && (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1 || mem_wdata !== wd)) side_ok = 1'b0;
                if (!wr && (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1)) side_ok = 1'b0;
            end
            if (req_ready) begin
                fast = rsp_burst;
                break;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        one_pulse = !req_ready && mem_cs_n;
        rd = rsp_rdata;
    endtask

    typedef struct packed {
        logic [2:0]  typ;
        logic        wr;
        logic [15:0] addr;
        logic [4:0]  cyc;
        logic        fast;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 37;
    // first wait 6 -> 7 cycles, next wait 2 -> 3 cycles
    localparam vec_t VEC [NV] = '{
        '{3'b010, 1'b0, 16'h0100, 5'd7, 1'b0, 8'd10},  // R10 first read after reset
        '{3'b010, 1'b0, 16'h0104, 5'd3, 1'b1, 8'd4},   // R4 offset 01
        '{3'b010, 1'b0, 16'h0108, 5'd3, 1'b1, 8'd4},   // R4 offset 10
        '{3'b010, 1'b0, 16'h010C, 5'd3, 1'b1, 8'd4},   // R4 offset 11
        '{3'b010, 1'b0, 16'h0110, 5'd7, 1'b0, 8'd6},   // R6 past window top
        '{3'b010, 1'b0, 16'h0114, 5'd3, 1'b1, 8'd4},   // R4 new burst continues
        '{3'b010, 1'b0, 16'h011C, 5'd7, 1'b0, 8'd6},   // R6 skipped word
        '{3'b010, 1'b1, 16'h0120, 5'd7, 1'b0, 8'd3},   // R3 write
        '{3'b010, 1'b0, 16'h0124, 5'd7, 1'b0, 8'd8},   // R8 read after write
        '{3'b010, 1'b0, 16'h0128, 5'd3, 1'b1, 8'd4},   // R4
        '{3'b010, 1'b0, 16'h112C, 5'd7, 1'b0, 8'd7},   // R7 upper bits differ
        '{3'b011, 1'b0, 16'h0200, 5'd7, 1'b0, 8'd5},   // R5 burst-of-eight start
        '{3'b011, 1'b0, 16'h0204, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h0208, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h020C, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h0210, 5'd3, 1'b1, 8'd5},   // R5 crosses 4-word line
        '{3'b011, 1'b0, 16'h0214, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h0218, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h021C, 5'd3, 1'b1, 8'd5},
        '{3'b011, 1'b0, 16'h0220, 5'd7, 1'b0, 8'd6},   // R6 past 8-word top
        '{3'b011, 1'b0, 16'h0300, 5'd7, 1'b0, 8'd5},
        '{3'b011, 1'b1, 16'h0304, 5'd7, 1'b0, 8'd3},   // R3 sequential write stays slow
        '{3'b011, 1'b0, 16'h0308, 5'd7, 1'b0, 8'd8},   // R8
        '{3'b000, 1'b0, 16'h0400, 5'd7, 1'b0, 8'd9},   // R9 plain
        '{3'b000, 1'b0, 16'h0404, 5'd7, 1'b0, 8'd9},
        '{3'b001, 1'b0, 16'h0408, 5'd7, 1'b0, 8'd9},   // R9 SRAM
        '{3'b100, 1'b0, 16'h040C, 5'd7, 1'b0, 8'd9},   // R9 variable latency
        '{3'b101, 1'b0, 16'h0410, 5'd7, 1'b0, 8'd9},   // R9 unused code
        '{3'b110, 1'b0, 16'h0414, 5'd7, 1'b0, 8'd9},
        '{3'b111, 1'b0, 16'h0418, 5'd7, 1'b0, 8'd9},
        '{3'b010, 1'b0, 16'h0508, 5'd7, 1'b0, 8'd7},
        '{3'b010, 1'b0, 16'h0504, 5'd7, 1'b0, 8'd6},   // R6 backward step
        '{3'b010, 1'b0, 16'h0508, 5'd3, 1'b1, 8'd4},
        '{3'b011, 1'b0, 16'h0600, 5'd7, 1'b0, 8'd5},
        '{3'b011, 1'b0, 16'h0604, 5'd3, 1'b1, 8'd5},
        '{3'b010, 1'b0, 16'h0608, 5'd3, 1'b1, 8'd4},   // R4 mode change, still in 4-window
        '{3'b010, 1'b0, 16'h060C, 5'd3, 1'b1, 8'd4}
    };

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual expired expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int               cyc;
        logic             fast, side_ok, one_pulse;
        logic [DATA_W-1:0] rd;
        string            tag;

        // R1: reset state
        repeat (2) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !req_ready, "R1", "reset strobes",
              {mem_cs_n, mem_oe_n, mem_we_n, req_ready}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && !req_ready, "R1", "idle after reset", {mem_cs_n, req_ready}, 2'b10);

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d", VEC[v].tag);
            run_access(VEC[v].typ, VEC[v].wr, ADDR_W'(VEC[v].addr), 32'hA000_0000 + v,
                       cyc, fast, rd, side_ok, one_pulse);
            check(cyc == int'(VEC[v].cyc), tag, "cycles", cyc, VEC[v].cyc);
            check(fast == VEC[v].fast, tag, "burst flag", fast, VEC[v].fast);
            check(side_ok, "R11", "addr/data/strobes during access", side_ok, 1);
            check(one_pulse, "R2", "ready single pulse", one_pulse, 1);
            if (!VEC[v].wr)
                check(rd == model_rd(ADDR_W'(VEC[v].addr)), "R11", "read data",
                      rd, model_rd(ADDR_W'(VEC[v].addr)));
        end

        // R2: wait counts at both ends of the range
        cfg_first_wait = 4'd0; cfg_next_wait = 4'd0;
        run_access(3'b010, 1'b0, 26'h0700, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        check(cyc == 1 && !fast, "R2", "zero first wait", cyc, 1);
        run_access(3'b010, 1'b0, 26'h0704, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        check(cyc == 1 && fast, "R2", "zero next wait", cyc, 1);
        cfg_first_wait = 4'd15; cfg_next_wait = 4'd15;
        run_access(3'b010, 1'b0, 26'h0800, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        check(cyc == 16, "R2", "max first wait", cyc, 16);
        run_access(3'b010, 1'b0, 26'h0804, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        check(cyc == 16 && fast, "R2", "max next wait", cyc, 16);

        // R10: reset in the middle of a burst
        cfg_first_wait = 4'd6; cfg_next_wait = 4'd2;
        run_access(3'b010, 1'b0, 26'h0900, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        do_reset();
        check(mem_cs_n && mem_oe_n && mem_we_n && !req_ready, "R1", "strobes after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, req_ready}, 4'b1110);
        run_access(3'b010, 1'b0, 26'h0904, 32'h0, cyc, fast, rd, side_ok, one_pulse);
        check(cyc == 7 && !fast, "R10", "read after reset is first access", cyc, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule